// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block feeds a transmit data path from a circular list of buffer descriptors kept in system memory. Each descriptor is two 32-bit words. The first word holds a 16-bit status/flag halfword in bits [31:16] and a 16-bit byte count in bits [15:0]. The second word holds the buffer's byte address. Software fills descriptors, marks them as owned by hardware and releases the engine from its halted state with a one-cycle clear pulse. The engine then takes descriptors in turn. For each one it streams the buffer out as bytes over a valid/ready interface, then writes the first word back with ownership returned to software.

The engine parks itself when it fetches a descriptor that software has not handed over. It stays parked until software pulses the clear input again, and then it refetches that same descriptor. A per-descriptor wrap flag closes the ring back to the programmed base, so the ring length is set by software and not by the hardware. A held stop request lets the frame in progress drain, through its last-in-frame buffer, and then holds the engine still and reports completion. Dropping the request lets the engine continue.

Memory is a simple word port with a fixed read latency of one cycle. Descriptor and buffer words are little-endian: the byte at address a sits in bits [8*(a mod 4)+7 : 8*(a mod 4)] of its word.

Top module: `tx_ring_engine`

## Requirements
- R1: After reset the engine is halted (`halted`=1), `tx_valid`=0, `stop_done`=0, and it makes no memory access until `halt_clear` is pulsed.
- R2: The first `halt_clear` after reset starts fetching at `ring_base` with its low three bits forced to zero. The status/length word is read at that address and the buffer pointer at address+4.
- R3: A fetched descriptor with status bit 15 (hardware-owned) clear puts the engine in the halted state. There it makes no memory access and stays until `halt_clear`, which makes it refetch that same descriptor.
- R4: An owned descriptor produces exactly `length` bytes, taken in ascending address order from any byte-aligned buffer pointer. A length of zero produces no bytes.
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.
- R6: `tx_last` is high only on the final byte of a buffer whose status bit 11 (last in frame) is set. `tx_crc` equals status bit 10 (append CRC) on every byte of that buffer.
- R7: After the final byte, the first descriptor word is written back. In it status bit 15 and the error bits [5:0] are cleared, and all other status bits and the length are unchanged.
- R8: The next descriptor is fetched at the current address plus 8. If status bit 13 (wrap) is set, it is fetched at the aligned ring base instead.
- R9: While `stop_req` is held, the engine completes the buffer with the last-in-frame flag and then stops. It raises `stop_done`, makes no memory access and sends no byte. Lowering `stop_req` clears `stop_done` one cycle later, and fetching resumes.
- R10: A `halt_clear` pulse while the engine is not halted has no effect.
- R11: A `stop_req` raised while the engine is halted raises `stop_done` on the next clock edge, and the engine stays halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ring_base | input | ADDR_W | Descriptor ring start address (low 3 bits ignored) |
| halt_clear | input | 1 | One-cycle pulse that leaves the halted state |
| stop_req | input | 1 | Level request for a stop at a frame boundary |
| halted | output | 1 | Engine is parked on a descriptor it does not own |
| stop_done | output | 1 | Stop request honoured; engine idle |
| mem_rd | output | 1 | Word read request; data is returned on the next cycle |
| mem_wr | output | 1 | Word write strobe |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_wdata | output | 32 | Write data (descriptor write-back) |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_rd` |
| tx_valid | output | 1 | Byte available |
| tx_ready | input | 1 | Consumer accepts the byte |
| tx_data | output | 8 | Byte value |
| tx_last | output | 1 | Final byte of a frame |
| tx_crc | output | 1 | Append-CRC request for the current buffer |

## Verification
On every cycle the assertions check that a stalled byte is held, that write-backs always release ownership and clear the error bits, and that only a clear pulse leaves the halted state. They also check that a halted or stopped engine stays off the memory port and the byte stream, and that `stop_done` follows the request down. The directed scenarios are needed to show the things that depend on the ring's contents. These are the byte order across unaligned buffers, the exact byte counts and `tx_last` placement, the wrap back to the base and the refetch after a restart, the frame-boundary choice of stop point, and the untouched ownership of a descriptor that was held back by a stop.

// File: rtl/txr_pkg.sv
// Shared constants and types for the transmit descriptor ring engine.
// Assumes 32-bit memory words split into a 16-bit status and 16-bit length.
package txr_pkg;
    localparam int WORD_W = 32;
    localparam int HALF_W = 16;
    localparam int BYTE_W = 8;

    // Status bit positions within the status halfword
    localparam int ST_OWN  = 15;
    localparam int ST_WRAP = 13;
    localparam int ST_LAST = 11;
    localparam int ST_CRC  = 10;
    localparam int ERR_W   = 6;

    localparam logic [HALF_W-1:0] OWN_MASK = HALF_W'(1) << ST_OWN;
    localparam logic [HALF_W-1:0] ERR_MASK = HALF_W'((1 << ERR_W) - 1);

    typedef enum logic [3:0] {
        S_HALT, S_RD0, S_GET0, S_RD1, S_GET1,
        S_RDB, S_GETB, S_SEND, S_WB, S_STOP
    } txr_state_t;

    // Status value returned to software after a normal completion
    function automatic logic [HALF_W-1:0] release_status(input logic [HALF_W-1:0] s);
        return s & ~(OWN_MASK | ERR_MASK);
    endfunction
endpackage

// File: rtl/txr_ring_ptr.sv
// Descriptor address register. Loads the aligned ring base on request and
// steps by one descriptor, or back to the base when the wrap flag is set.
// Assumes the base is stable while the engine is running.
module txr_ring_ptr #(
    parameter int ADDR_W = 32,
    parameter int DESC_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base,
    input  logic              load,
    input  logic              step,
    input  logic              wrap,
    output logic [ADDR_W-1:0] cur
);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'(DESC_BYTES - 1);
    localparam logic [ADDR_W-1:0] STEP       = ADDR_W'(DESC_BYTES);

    logic [ADDR_W-1:0] base_al;
    assign base_al = base & ~ALIGN_MASK;

    // Descriptor pointer update: reload, advance or wrap
    always_ff @(posedge clk) begin
        if (!rst_n)      cur <= '0;
        else if (load)   cur <= base_al;
        else if (step)   cur <= wrap ? base_al : cur + STEP;
    end
endmodule

// File: rtl/txr_byte_pick.sv
// Selects one byte lane of a memory word (little-endian lane order).
// Assumes WORD_W is a multiple of 8.
module txr_byte_pick #(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0]             word,
    input  logic [$clog2(WORD_W/8)-1:0]   sel,
    output logic [7:0]                    byte_o
);
    localparam int LANES = WORD_W / 8;
    logic [7:0] lanes [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g] = word[g*8 +: 8];
    end

    // Lane multiplexer
    assign byte_o = lanes[sel];
endmodule

// File: rtl/tx_ring_engine.sv
// Transmit descriptor ring engine. Walks a ring of two-word descriptors,
// streams each owned buffer out as bytes, writes the descriptor back with
// ownership released, and parks on the first descriptor it does not own.
// Assumes a memory port with one-cycle read latency and ADDR_W <= 32.
module tx_ring_engine
    import txr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic              halt_clear,
    input  logic              stop_req,
    output logic              halted,
    output logic              stop_done,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    output logic              tx_crc
);
    localparam int LANE_W = $clog2(WORD_W / BYTE_W);
    localparam logic [ADDR_W-1:0] PTR_OFS  = ADDR_W'(WORD_W / BYTE_W);
    localparam logic [ADDR_W-1:0] ONE_A    = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] LANE_MSK = ADDR_W'((1 << LANE_W) - 1);

    txr_state_t        state, state_n;
    logic              fresh;
    logic [HALF_W-1:0] d_stat, d_len, remain;
    logic [ADDR_W-1:0] byte_addr, cur;
    logic [WORD_W-1:0] buf_word;
    logic              ptr_load, ptr_step;
    logic              lane_end;

    txr_ring_ptr #(.ADDR_W(ADDR_W), .DESC_BYTES(8)) u_ptr (
        .clk(clk), .rst_n(rst_n), .base(ring_base),
        .load(ptr_load), .step(ptr_step), .wrap(d_stat[ST_WRAP]), .cur(cur)
    );

    txr_byte_pick #(.WORD_W(WORD_W)) u_pick (
        .word(buf_word), .sel(byte_addr[LANE_W-1:0]), .byte_o(tx_data)
    );

    assign lane_end = &byte_addr[LANE_W-1:0];
    assign halted   = (state == S_HALT);
    assign ptr_load = halted && halt_clear && fresh;
    assign ptr_step = (state == S_WB);
    assign tx_valid = (state == S_SEND);
    assign tx_last  = tx_valid && d_stat[ST_LAST] && (remain == HALF_W'(1));
    assign tx_crc   = tx_valid && d_stat[ST_CRC];
    assign mem_wr   = (state == S_WB);
    assign mem_wdata = {release_status(d_stat), d_len};

    // Memory request decode per state
    always_comb begin
        mem_rd   = 1'b0;
        mem_addr = cur;
        unique case (state)
            S_RD0: mem_rd = 1'b1;
            S_RD1: begin mem_rd = 1'b1; mem_addr = cur + PTR_OFS; end
            S_RDB: begin mem_rd = 1'b1; mem_addr = byte_addr & ~LANE_MSK; end
            default: ;
        endcase
    end

    // Next-state selection
    always_comb begin
        state_n = state;
        unique case (state)
            S_HALT: if (halt_clear) state_n = S_RD0;
            S_RD0:  state_n = S_GET0;
            S_GET0: state_n = mem_rdata[HALF_W + ST_OWN] ? S_RD1 : S_HALT;
            S_RD1:  state_n = S_GET1;
            S_GET1: state_n = (d_len == '0) ? S_WB : S_RDB;
            S_RDB:  state_n = S_GETB;
            S_GETB: state_n = S_SEND;
            S_SEND: if (tx_ready) begin
                        if (remain == HALF_W'(1)) state_n = S_WB;
                        else if (lane_end)        state_n = S_RDB;
                    end
            S_WB:   state_n = (stop_req && d_stat[ST_LAST]) ? S_STOP : S_RD0;
            S_STOP: if (!stop_req) state_n = S_RD0;
            default: state_n = S_HALT;
        endcase
    end

    // State, stop flag and first-start marker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_HALT;
            fresh     <= 1'b1;
            stop_done <= 1'b0;
        end else begin
            state     <= state_n;
            stop_done <= stop_req && (state_n == S_STOP || state_n == S_HALT);
            if (ptr_load) fresh <= 1'b0;
        end
    end

    // Descriptor fields, buffer cursor and word holding register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_stat    <= '0;
            d_len     <= '0;
            remain    <= '0;
            byte_addr <= '0;
            buf_word  <= '0;
        end else begin
            unique case (state)
                S_GET0: begin
                    d_stat <= mem_rdata[WORD_W-1:HALF_W];
                    d_len  <= mem_rdata[HALF_W-1:0];
                end
                S_GET1: begin
                    byte_addr <= mem_rdata[ADDR_W-1:0];
                    remain    <= d_len;
                end
                S_GETB: buf_word <= mem_rdata;
                S_SEND: if (tx_ready) begin
                    byte_addr <= byte_addr + ONE_A;
                    remain    <= remain - HALF_W'(1);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/txr_checks.sv
// Cycle-level checks for tx_ring_engine, attached by bind.
module txr_checks #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              halted,
    input logic              halt_clear,
    input logic              stop_req,
    input logic              stop_done,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [7:0]        tx_data,
    input logic              tx_last
);
    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));
    // R7
    wb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> !mem_wdata[31] && (mem_wdata[21:16] == 6'd0));
    // R8
    wb_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_addr[2:0] == 3'd0));
    // R3
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_rd && !mem_wr && !tx_valid);
    // R3
    halt_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted && !halt_clear |=> halted);
    // R9
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_done |-> !mem_rd && !mem_wr && !tx_valid);
    // R9
    stop_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_req |=> !stop_done);
endmodule

bind tx_ring_engine txr_checks #(.ADDR_W(ADDR_W)) u_txr_checks (
    .clk(clk), .rst_n(rst_n), .halted(halted), .halt_clear(halt_clear),
    .stop_req(stop_req), .stop_done(stop_done), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_last(tx_last)
);

// File: tb/test_tx_ring_engine.sv
// Directed bench for tx_ring_engine: one task per scenario.
module test_tx_ring_engine;
    localparam logic [15:0] F_OWN  = 16'h8000;
    localparam logic [15:0] F_WRAP = 16'h2000;
    localparam logic [15:0] F_INT  = 16'h1000;
    localparam logic [15:0] F_LAST = 16'h0800;
    localparam logic [15:0] F_CRC  = 16'h0400;
    localparam logic [31:0] BASE   = 32'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ring_base = BASE | 32'h3;
    logic        halt_clear = 1'b0;
    logic        stop_req = 1'b0;
    logic        halted, stop_done, mem_rd, mem_wr;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        tx_valid, tx_last, tx_crc;
    logic        tx_ready = 1'b1;
    logic [7:0]  tx_data;

    logic [31:0] mem [256];
    logic [31:0] last_rd_addr = '0;
    int          acc_cnt = 0;
    logic [7:0]  cap_data [256];
    logic        cap_last [256];
    logic        cap_crc  [256];
    int          cap_n = 0;
    bit          stall_mode = 1'b0;
    logic [7:0]  lfsr = 8'hA5;
    int          n_chk = 0;
    int          n_bad = 0;

    tx_ring_engine #(.ADDR_W(32)) i_tx_ring_engine (
        .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .halt_clear(halt_clear),
        .stop_req(stop_req), .halted(halted), .stop_done(stop_done),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last), .tx_crc(tx_crc)
    );

    always #2 clk = ~clk;

    // Memory model: one-cycle read latency, word writes
    always @(posedge clk) begin
        if (mem_rd) begin
            mem_rdata    <= mem[mem_addr[9:2]];
            last_rd_addr <= mem_addr;
        end
        if (mem_wr) mem[mem_addr[9:2]] <= mem_wdata;
        if (mem_rd || mem_wr) acc_cnt <= acc_cnt + 1;
    end

    // Byte sink capture
    always @(posedge clk) begin
        if (tx_valid && tx_ready) begin
            cap_data[cap_n[7:0]] <= tx_data;
            cap_last[cap_n[7:0]] <= tx_last;
            cap_crc[cap_n[7:0]]  <= tx_crc;
            cap_n <= cap_n + 1;
        end
    end

    // Consumer ready pattern
    always @(negedge clk) begin
        lfsr     <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        tx_ready <= stall_mode ? lfsr[0] : 1'b1;
    end

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 13) + 7);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    task automatic put_desc(input logic [31:0] a, input logic [15:0] st, input logic [15:0] len, input logic [31:0] p);
        mem[a[9:2]]        = {st, len};
        mem[a[9:2] + 8'd1] = p;
    endtask

    task automatic pulse_clear();
        @(negedge clk) halt_clear = 1'b1;
        @(negedge clk) halt_clear = 1'b0;
    endtask

    task automatic wait_halt(input string req);
        int k;
        for (k = 0; k < 5000 && !halted; k++) @(negedge clk);
        chk(halted, req, {31'd0, halted}, 32'd1);
    endtask

    task automatic check_bytes(input string req, input int start, input int p, input int len, input bit lf, input bit cf);
        for (int i = 0; i < len; i++) begin
            chk(cap_data[start+i] == pat(p+i), req, 32'(cap_data[start+i]), 32'(pat(p+i)));
            chk(cap_last[start+i] == (lf && i == len-1), "R6", 32'(cap_last[start+i]), 32'(lf && i == len-1));
            chk(cap_crc[start+i] == cf, "R6", 32'(cap_crc[start+i]), 32'(cf));
        end
    endtask

    function automatic logic [31:0] wb_word(input logic [15:0] st, input logic [15:0] len);
        return {st & 16'h7FC0, len};
    endfunction

    task automatic t_reset();
        int a0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(halted == 1'b1, "R1", 32'(halted), 1);
        chk(tx_valid == 1'b0, "R1", 32'(tx_valid), 0);
        chk(stop_done == 1'b0, "R1", 32'(stop_done), 0);
        a0 = acc_cnt;
        repeat (10) @(negedge clk);
        chk(acc_cnt == a0, "R1", 32'(acc_cnt), 32'(a0));
    endtask

    task automatic t_basic_ring();
        int s;
        logic [15:0] st0, st1;
        st0 = F_OWN | F_LAST | F_CRC | 16'h0005;
        st1 = F_OWN | F_LAST | F_WRAP | F_INT;
        put_desc(BASE, st0, 16'd5, 32'h203);
        put_desc(BASE + 8, st1, 16'd6, 32'h240);
        s = cap_n;
        pulse_clear();
        // R2: first fetch at the aligned base, pointer word at base+4
        chk(mem_rd && mem_addr == BASE, "R2", mem_addr, BASE);
        @(negedge clk); @(negedge clk);
        chk(mem_rd && mem_addr == BASE + 4, "R2", mem_addr, BASE + 4);
        wait_halt("R3");
        chk(cap_n - s == 11, "R4", 32'(cap_n - s), 11);
        check_bytes("R4", s, 32'h203, 5, 1'b1, 1'b1);
        check_bytes("R4", s + 5, 32'h240, 6, 1'b1, 1'b0);
        chk(mem[BASE[9:2]] == wb_word(st0, 16'd5), "R7", mem[BASE[9:2]], wb_word(st0, 16'd5));
        chk(mem[8'(BASE[9:2] + 2)] == wb_word(st1, 16'd6), "R7", mem[8'(BASE[9:2] + 2)], wb_word(st1, 16'd6));
        // R8: wrap sends the engine back to the base, where it parks
        chk(last_rd_addr == BASE, "R8", last_rd_addr, BASE);
    endtask

    task automatic t_restart_stall();
        int s, a0;
        put_desc(BASE, F_OWN | F_CRC, 16'd9, 32'h301);
        put_desc(BASE + 8, F_OWN | F_LAST | F_WRAP, 16'd3, 32'h2F0);
        stall_mode = 1'b1;
        s = cap_n;
        a0 = acc_cnt;
        repeat (5) @(negedge clk);
        chk(acc_cnt == a0 && halted, "R3", 32'(acc_cnt), 32'(a0));
        pulse_clear();
        repeat (6) @(negedge clk);
        pulse_clear();   // R10: not halted, so ignored
        wait_halt("R3");
        stall_mode = 1'b0;
        chk(cap_n - s == 12, "R10", 32'(cap_n - s), 12);
        check_bytes("R5", s, 32'h301, 9, 1'b0, 1'b1);
        check_bytes("R3", s + 9, 32'h2F0, 3, 1'b1, 1'b0);
    endtask

    task automatic t_zero_len();
        int s;
        put_desc(BASE, F_OWN | F_LAST | F_WRAP, 16'd0, 32'h200);
        s = cap_n;
        pulse_clear();
        wait_halt("R4");
        chk(cap_n == s, "R4", 32'(cap_n - s), 0);
        chk(mem[BASE[9:2]] == wb_word(F_LAST | F_WRAP, 16'd0), "R7", mem[BASE[9:2]], wb_word(F_LAST | F_WRAP, 16'd0));
        chk(last_rd_addr == BASE, "R8", last_rd_addr, BASE);
    endtask

    task automatic t_graceful_stop();
        int s, a0, k;
        logic [15:0] st2;
        st2 = F_OWN | F_LAST | F_WRAP;
        put_desc(BASE, F_OWN, 16'd4, 32'h210);
        put_desc(BASE + 8, F_OWN | F_LAST, 16'd4, 32'h220);
        put_desc(BASE + 16, st2, 16'd2, 32'h230);
        stall_mode = 1'b1;
        s = cap_n;
        pulse_clear();
        stop_req = 1'b1;
        for (k = 0; k < 5000 && !stop_done; k++) @(negedge clk);
        chk(stop_done == 1'b1, "R9", 32'(stop_done), 1);
        chk(tx_valid == 1'b0 && !halted, "R9", 32'(tx_valid), 0);
        chk(cap_n - s == 8, "R9", 32'(cap_n - s), 8);
        check_bytes("R9", s, 32'h210, 4, 1'b0, 1'b0);
        check_bytes("R9", s + 4, 32'h220, 4, 1'b1, 1'b0);
        chk(mem[8'(BASE[9:2] + 4)] == {st2, 16'd2}, "R9", mem[8'(BASE[9:2] + 4)], {st2, 16'd2});
        a0 = acc_cnt;
        repeat (20) @(negedge clk);
        chk(acc_cnt == a0, "R9", 32'(acc_cnt), 32'(a0));
        stop_req = 1'b0;
        @(negedge clk);
        chk(stop_done == 1'b0, "R9", 32'(stop_done), 0);
        wait_halt("R9");
        stall_mode = 1'b0;
        chk(cap_n - s == 10, "R9", 32'(cap_n - s), 10);
        check_bytes("R8", s + 8, 32'h230, 2, 1'b1, 1'b0);
        chk(mem[8'(BASE[9:2] + 4)] == wb_word(st2, 16'd2), "R7", mem[8'(BASE[9:2] + 4)], wb_word(st2, 16'd2));
        chk(last_rd_addr == BASE, "R8", last_rd_addr, BASE);
    endtask

    task automatic t_stop_while_halted();
        @(negedge clk) stop_req = 1'b1;
        @(negedge clk);
        chk(stop_done == 1'b1, "R11", 32'(stop_done), 1);
        chk(halted == 1'b1, "R11", 32'(halted), 1);
        stop_req = 1'b0;
        @(negedge clk);
        chk(stop_done == 1'b0, "R11", 32'(stop_done), 0);
    endtask

    // Watchdog
    initial begin
        #(4 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        for (int i = 0; i < 256; i++)
            mem[i] = {pat(4*i+3), pat(4*i+2), pat(4*i+1), pat(4*i)};
        t_reset();
        t_basic_ring();
        t_restart_stall();
        t_zero_len();
        t_graceful_stop();
        t_stop_while_halted();
        summary();
    end
endmodule